// File: doc/BRIEF.md
# Arbitrated Message Capture and Host Interrupt Unit

This unit receives arbitrated messages from the bus side and makes them available to a local host through a small synchronous register port. Each incoming message arrives as a one-cycle valid strobe carrying a byte and two qualifiers. The first qualifier says the message is aimed at this module. The second marks it as a power-fail notice. General messages go into a shallow first-in first-out queue. A targeted message is held in its own register. A power-fail notice drives a dedicated output. Each of these events latches a bit in an interrupt status register.

The host reaches the registers with a 12-bit address and an 8-bit data path that carries an odd parity bit. Chip enable, output enable and write enable are all active low. A read latches the selected register on the first clock of the read cycle and drives it with odd parity. A write is accepted on the first clock of the write cycle, but only when its parity is correct. A mask register selects which status bits pull the active-low host interrupt. Status bits are cleared by writing zero to them. While a write cycle to the status register is in progress, the interrupt output is forced inactive.

The register map is as follows. Address 0x000 is the queue data register; reading it pops one entry. Address 0x001 holds the entry count. Address 0x002 is the targeted-message register. Address 0x003 is the interrupt status register. Address 0x004 is the interrupt mask register. All other addresses read as zero. The status bits are: bit 0 for a queued message, bit 1 for a targeted message, bit 2 for power fail, bit 3 for queue overflow, and bit 4 for write parity error.

Top module: `msgIrqTop`

## Requirements
- R1: General messages leave the queue in arrival order, one per read of address 0x000. A read of 0x000 while the queue is empty returns 0x00 and changes nothing.
- R2: Address 0x001 reads the number of queued entries, from 0 to 4, and reads 0 after reset.
- R3: A general message arriving while four entries are held is discarded, and status bit 3 is set. Bit 3 stays set until it is cleared by a write.
- R4: A message with the targeted flag set is stored in the register at 0x002 and sets status bit 1. It does not enter the queue.
- R5: A message with the power-fail flag set (this flag takes priority over the targeted flag) sets status bit 2 and does not enter the queue. The active-low power-fail output is low exactly while status bit 2 is set, and it is high after reset.
- R6: Outside a status write cycle, the host interrupt output is low if and only if some bit is set in both the status register and the mask register at 0x004. The low five bits of the mask register are writable; all mask bits reset to 0.
- R7: A valid write to 0x003 clears each status bit whose data bit is 0 and leaves unchanged each status bit whose data bit is 1.
- R8: While chip enable and write enable are both low with address 0x003, the interrupt output is high even if an enabled bit is pending. It returns low after the write if an enabled bit remains.
- R9: Read data is driven with odd parity: the eight data bits plus the parity bit hold an odd number of ones.
- R10: A write whose data and parity bits hold an even number of ones changes no register and sets status bit 4.
- R11: A general message stored in the queue sets status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostAddr | input | 12 | Register address |
| hostDataIn | input | 8 | Write data |
| hostParIn | input | 1 | Odd parity bit of the write data |
| hostCeN | input | 1 | Chip enable, active low |
| hostOeN | input | 1 | Output enable (read), active low |
| hostWeN | input | 1 | Write enable, active low |
| hostDataOut | output | 8 | Read data, latched at the start of a read cycle |
| hostParOut | output | 1 | Odd parity bit of the read data |
| msgValid | input | 1 | One-cycle strobe for a received message |
| msgByte | input | 8 | Received message byte |
| msgTargeted | input | 1 | Message is addressed to this module |
| msgPowerFail | input | 1 | Message is a power-fail notice |
| irqN | output | 1 | Host interrupt, active low |
| pwrFailN | output | 1 | Power-fail indication, active low |

## Verification
The bench uses the default parameters: a 12-bit address, an 8-bit data path and a queue depth of four. With 8-bit data, every byte value can be written with both parity settings, so every good-parity and bad-parity write is covered against the mask register. With a depth of four, the sweep over message counts 0 to 5 reaches the empty queue, the full queue and overflow within a few cycles. Expected queue contents, counts, status bits and interrupt levels come from a small model kept in the bench.

// File: rtl/msgIrqPkg.sv
package msgIrqPkg;

  localparam int NUM_IRQ  = 5;
  localparam int BIT_AVAIL = 0;
  localparam int BIT_TGT   = 1;
  localparam int BIT_PF    = 2;
  localparam int BIT_OVF   = 3;
  localparam int BIT_PAR   = 4;

  localparam int REG_QDATA = 0;
  localparam int REG_COUNT = 1;
  localparam int REG_TGT   = 2;
  localparam int REG_STAT  = 3;
  localparam int REG_MASK  = 4;

  typedef enum logic [2:0] {
    SEL_QDATA,
    SEL_COUNT,
    SEL_TGT,
    SEL_STAT,
    SEL_MASK,
    SEL_NONE
  } rdSel_e;

  typedef struct packed {
    logic               push;
    logic               pop;
    logic               tgtLoad;
    logic [NUM_IRQ-1:0] setBits;
    logic               statWr;
    logic               maskWr;
    logic               rdLatch;
    rdSel_e             rdSel;
  } strobes_t;

endpackage

// File: rtl/msgIrqCtrl.sv
module msgIrqCtrl
  import msgIrqPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostDataIn,
  input  logic              hostParIn,
  input  logic              hostCeN,
  input  logic              hostOeN,
  input  logic              hostWeN,
  input  logic              msgValid,
  input  logic              msgTargeted,
  input  logic              msgPowerFail,
  input  logic              queueFull,
  input  logic              queueEmpty,
  output strobes_t          strb,
  output logic              statWindow
);

  logic rdActive, wrActive, prevRd, prevWr, rdStart, wrStart, parityOk;
  rdSel_e sel;

  assign rdActive = !hostCeN && !hostOeN;
  assign wrActive = !hostCeN && !hostWeN;
  assign rdStart  = rdActive && !prevRd;
  assign wrStart  = wrActive && !prevWr;
  assign parityOk = ^{hostDataIn, hostParIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevRd <= 1'b0;
      prevWr <= 1'b0;
    end else begin
      prevRd <= rdActive;
      prevWr <= wrActive;
    end
  end

  always_comb begin
    if      (hostAddr == ADDR_W'(REG_QDATA)) sel = SEL_QDATA;
    else if (hostAddr == ADDR_W'(REG_COUNT)) sel = SEL_COUNT;
    else if (hostAddr == ADDR_W'(REG_TGT))   sel = SEL_TGT;
    else if (hostAddr == ADDR_W'(REG_STAT))  sel = SEL_STAT;
    else if (hostAddr == ADDR_W'(REG_MASK))  sel = SEL_MASK;
    else                                     sel = SEL_NONE;
  end

  assign statWindow = wrActive && (sel == SEL_STAT);

  always_comb begin
    strb         = '0;
    strb.rdSel   = sel;
    strb.rdLatch = rdStart;
    strb.pop     = rdStart && (sel == SEL_QDATA) && !queueEmpty;
    if (wrStart) begin
      if (parityOk) begin
        strb.statWr = (sel == SEL_STAT);
        strb.maskWr = (sel == SEL_MASK);
      end else begin
        strb.setBits[BIT_PAR] = 1'b1;
      end
    end
    if (msgValid) begin
      if (msgPowerFail) begin
        strb.setBits[BIT_PF] = 1'b1;
      end else if (msgTargeted) begin
        strb.tgtLoad          = 1'b1;
        strb.setBits[BIT_TGT] = 1'b1;
      end else if (queueFull) begin
        strb.setBits[BIT_OVF] = 1'b1;
      end else begin
        strb.push               = 1'b1;
        strb.setBits[BIT_AVAIL] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/msgIrqDatapath.sv
module msgIrqDatapath
  import msgIrqPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobes_t           strb,
  input  logic [DATA_W-1:0]  msgByte,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               wrPar,
  output logic [DATA_W-1:0]  rdData,
  output logic [NUM_IRQ-1:0] stat,
  output logic [NUM_IRQ-1:0] mask,
  output logic               full,
  output logic               empty
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] tgtReg;
  logic [NUM_IRQ-1:0] statNext;

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

  function automatic logic [PTR_W-1:0] ptrInc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (strb.push && (wrPtr == PTR_W'(e))) mem[e] <= msgByte;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.push) wrPtr <= ptrInc(wrPtr);
      if (strb.pop)  rdPtr <= ptrInc(rdPtr);
      case ({strb.push, strb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_comb begin
    for (int b = 0; b < NUM_IRQ; b++) begin
      if (strb.setBits[b])                  statNext[b] = 1'b1;
      else if (strb.statWr && !wrData[b])   statNext[b] = 1'b0;
      else                                  statNext[b] = stat[b];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stat   <= '0;
      mask   <= '0;
      tgtReg <= '0;
      rdData <= '0;
    end else begin
      stat <= statNext;
      if (strb.maskWr)  mask   <= wrData[NUM_IRQ-1:0];
      if (strb.tgtLoad) tgtReg <= msgByte;
      if (strb.rdLatch) begin
        case (strb.rdSel)
          SEL_QDATA: rdData <= empty ? '0 : mem[rdPtr];
          SEL_COUNT: rdData <= DATA_W'(count);
          SEL_TGT:   rdData <= tgtReg;
          SEL_STAT:  rdData <= DATA_W'(stat);
          SEL_MASK:  rdData <= DATA_W'(mask);
          default:   rdData <= '0;
        endcase
      end
    end
  end

  AST_COUNT_MAX: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH)); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> !full); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (stat[BIT_OVF] && !strb.statWr) |=> stat[BIT_OVF]); // R3
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> !empty); // R1
  AST_WR_PARITY_OK: assert property (@(posedge clk) disable iff (!rstN)
    (strb.statWr || strb.maskWr) |-> (^{wrData, wrPar})); // R10

endmodule

// File: rtl/msgIrqTop.sv
module msgIrqTop
  import msgIrqPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostDataIn,
  input  logic              hostParIn,
  input  logic              hostCeN,
  input  logic              hostOeN,
  input  logic              hostWeN,
  output logic [DATA_W-1:0] hostDataOut,
  output logic              hostParOut,
  input  logic              msgValid,
  input  logic [DATA_W-1:0] msgByte,
  input  logic              msgTargeted,
  input  logic              msgPowerFail,
  output logic              irqN,
  output logic              pwrFailN
);

  strobes_t           strb;
  logic               statWindow, full, empty;
  logic [NUM_IRQ-1:0] stat, mask;
  logic [DATA_W-1:0]  rdData;

  msgIrqCtrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostDataIn(hostDataIn),
    .hostParIn(hostParIn), .hostCeN(hostCeN), .hostOeN(hostOeN),
    .hostWeN(hostWeN), .msgValid(msgValid), .msgTargeted(msgTargeted),
    .msgPowerFail(msgPowerFail), .queueFull(full), .queueEmpty(empty),
    .strb(strb), .statWindow(statWindow)
  );

  msgIrqDatapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .msgByte(msgByte),
    .wrData(hostDataIn), .wrPar(hostParIn), .rdData(rdData),
    .stat(stat), .mask(mask), .full(full), .empty(empty)
  );

  assign hostDataOut = rdData;
  assign hostParOut  = ~^rdData;
  assign irqN        = !((|(stat & mask)) && !statWindow);
  assign pwrFailN    = !stat[BIT_PF];

  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (!hostCeN && !hostWeN && hostAddr == ADDR_W'(REG_STAT)) |-> irqN); // R8

endmodule

// File: tb/test_msgIrqTop.sv
module test_msgIrqTop;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] hostAddr = '0;
  logic [7:0]  hostDataIn = '0;
  logic        hostParIn = 1'b0;
  logic        hostCeN = 1'b1, hostOeN = 1'b1, hostWeN = 1'b1;
  logic [7:0]  hostDataOut;
  logic        hostParOut;
  logic        msgValid = 1'b0;
  logic [7:0]  msgByte = '0;
  logic        msgTargeted = 1'b0, msgPowerFail = 1'b0;
  logic        irqN, pwrFailN;

  int total = 0;
  int bad = 0;
  int expStat = 0;
  int expMask = 0;
  int expTgt = 0;
  int expQ[$];

  always #2 clk = ~clk;

  msgIrqTop i_msgIrqTop (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostDataIn(hostDataIn),
    .hostParIn(hostParIn), .hostCeN(hostCeN), .hostOeN(hostOeN),
    .hostWeN(hostWeN), .hostDataOut(hostDataOut), .hostParOut(hostParOut),
    .msgValid(msgValid), .msgByte(msgByte), .msgTargeted(msgTargeted),
    .msgPowerFail(msgPowerFail), .irqN(irqN), .pwrFailN(pwrFailN)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic oddPar(input logic [7:0] d);
    return ~^d;
  endfunction

  task automatic hostWrite(input int addr, input logic [7:0] d, input logic p);
    @(negedge clk);
    hostAddr = 12'(addr); hostDataIn = d; hostParIn = p;
    hostCeN = 1'b0; hostWeN = 1'b0;
    #1;
    if (addr == 3) check(irqN === 1'b1, "R8 irq forced high in status write", int'(irqN), 1);
    @(negedge clk);
    hostCeN = 1'b1; hostWeN = 1'b1;
    if (($countones(d) + int'(p)) % 2 == 1) begin
      if (addr == 3) expStat = expStat & int'(d[4:0]);
      if (addr == 4) expMask = int'(d[4:0]);
    end else begin
      expStat = expStat | 16;
    end
    @(negedge clk);
  endtask

  task automatic hostRead(input int addr, output int val);
    @(negedge clk);
    hostAddr = 12'(addr);
    hostCeN = 1'b0; hostOeN = 1'b0;
    @(negedge clk);
    val = int'(hostDataOut);
    check((($countones(hostDataOut) + int'(hostParOut)) % 2) == 1, "R9 read parity odd",
          int'(hostParOut), int'(oddPar(hostDataOut)));
    hostCeN = 1'b1; hostOeN = 1'b1;
    @(negedge clk);
  endtask

  task automatic sendMsg(input logic [7:0] b, input logic tgt, input logic pf);
    @(negedge clk);
    msgByte = b; msgTargeted = tgt; msgPowerFail = pf; msgValid = 1'b1;
    @(negedge clk);
    msgValid = 1'b0; msgTargeted = 1'b0; msgPowerFail = 1'b0;
    if (pf) expStat = expStat | 4;
    else if (tgt) begin expStat = expStat | 2; expTgt = int'(b); end
    else if (expQ.size() == 4) expStat = expStat | 8;
    else begin expQ.push_back(int'(b)); expStat = expStat | 1; end
  endtask

  task automatic checkIrq(input string req);
    logic e;
    e = ((expStat & expMask) != 0) ? 1'b0 : 1'b1;
    check(irqN === e, req, int'(irqN), int'(e));
  endtask

  task automatic readCheck(input int addr, input int exp, input string req);
    int v;
    hostRead(addr, v);
    check(v == exp, req, v, exp);
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // Reset state
    check(irqN === 1'b1, "R6 irq idle after reset", int'(irqN), 1);
    check(pwrFailN === 1'b1, "R5 power-fail idle after reset", int'(pwrFailN), 1);
    readCheck(1, 0, "R2 count zero after reset");
    readCheck(3, 0, "R7 status zero after reset");
    readCheck(4, 0, "R6 mask zero after reset");
    readCheck(0, 0, "R1 empty queue reads zero");

    // Sweep every byte with both parity values into the mask register
    for (int d = 0; d < 256; d++) begin
      for (int p = 0; p < 2; p++) begin
        hostWrite(4, 8'(d), p[0]);
        readCheck(4, expMask, "R10 mask write accepted or ignored by parity");
        checkIrq("R6 irq level follows status and mask");
      end
    end
    readCheck(3, expStat, "R10 parity error bit set");
    hostWrite(3, 8'h00, oddPar(8'h00));
    readCheck(3, 0, "R7 status cleared by zero write");
    hostWrite(4, 8'h1F, oddPar(8'h1F));
    checkIrq("R6 irq idle with empty status");

    // Message counts 0..5 through the queue
    for (int k = 0; k <= 5; k++) begin
      for (int i = 0; i < k; i++) sendMsg(8'((k * 37 + i * 11 + 5) & 255), 1'b0, 1'b0);
      readCheck(1, expQ.size(), "R2 count after fill");
      readCheck(3, expStat, "R11 R3 status after fill");
      checkIrq("R6 irq after fill");
      while (expQ.size() > 0) begin
        int e;
        e = expQ.pop_front();
        readCheck(0, e, "R1 queue order");
        readCheck(1, expQ.size(), "R2 count after pop");
      end
      readCheck(0, 0, "R1 empty read returns zero");
      readCheck(1, 0, "R1 empty read leaves count");
      hostWrite(3, 8'h00, oddPar(8'h00));
      checkIrq("R8 irq released after clear");
    end

    // Overflow stays sticky across further traffic
    for (int i = 0; i < 5; i++) sendMsg(8'(200 + i), 1'b0, 1'b0);
    v = 0;
    hostRead(0, v);
    check(v == 200, "R3 overflow kept first entries", v, 200);
    void'(expQ.pop_front());
    sendMsg(8'hA5, 1'b0, 1'b0);
    readCheck(3, expStat, "R3 overflow bit sticky");
    while (expQ.size() > 0) begin
      int e;
      e = expQ.pop_front();
      readCheck(0, e, "R3 queue contents after overflow");
    end
    hostWrite(3, 8'h00, oddPar(8'h00));

    // Targeted message
    sendMsg(8'h3C, 1'b1, 1'b0);
    readCheck(2, 16'h3C, "R4 targeted register");
    readCheck(1, 0, "R4 targeted not queued");
    readCheck(3, expStat, "R4 targeted status bit");
    checkIrq("R6 irq on targeted");

    // Power-fail message with targeted flag also set
    sendMsg(8'h77, 1'b1, 1'b1);
    check(pwrFailN === 1'b0, "R5 power-fail output asserted", int'(pwrFailN), 0);
    readCheck(2, 16'h3C, "R5 power-fail not stored as targeted");
    readCheck(1, 0, "R5 power-fail not queued");
    readCheck(3, expStat, "R5 power-fail status bit");

    // Selective clear: drop bit 2, keep bit 1; irq must come back
    hostWrite(3, 8'hFB, oddPar(8'hFB));
    readCheck(3, expStat, "R7 selective zero clear");
    check(pwrFailN === 1'b1, "R5 power-fail released on clear", int'(pwrFailN), 1);
    checkIrq("R8 irq reasserts after status write");
    check(irqN === 1'b0, "R8 irq low with pending bit", int'(irqN), 0);

    // Masked off pending bit
    hostWrite(4, 8'h00, oddPar(8'h00));
    checkIrq("R6 masked status keeps irq high");

    // Bad parity status write changes nothing but bit 4
    hostWrite(3, 8'h00, ~oddPar(8'h00));
    readCheck(3, expStat, "R10 bad parity status write ignored");

    finishRun();
  end

endmodule